// File: doc/BRIEF.md
# Logical-OR Instruction Byte Decoder

This block consumes an instruction byte stream, one byte on each cycle where the valid input is high. It recognises the register, memory and immediate encodings of the bitwise-OR instruction family. It walks through any operand-size, LOCK and REX prefix bytes, then the opcode, the ModRM byte, an optional SIB byte, displacement bytes and immediate bytes. When the last byte of an instruction arrives, it produces one decoded record on the following cycle. The record carries the operand size, the operand direction, a memory-destination flag, 4-bit register indices, the immediate already extended to the operand size, the total byte count and an invalid-opcode fault flag.

Bytes that do not start an OR instruction, and group opcodes whose ModRM reg field selects a different operation, end decoding at once with a record flagged unsupported. After every record the decoder returns to the prefix state. Address generation, segment and paging checks and execution belong to later stages.

Top module: `or_insn_decoder`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` stays low until a complete instruction has been accepted.
- R2: Opcode 0x0C takes one immediate byte at 8-bit size. Opcode 0x0D takes 2 immediate bytes at 16-bit size and 4 bytes otherwise. Both report register index 0, no memory destination and `out_to_reg`=0.
- R3: Opcodes 0x80, 0x81 and 0x83 decode only when ModRM bits [5:3] equal 1. Their immediates are 1 byte, 2 or 4 bytes by size, and 1 byte, respectively. Any other reg value emits an unsupported record right after the ModRM byte.
- R4: For 0x08/0x09 the r/m operand is the destination (`out_to_reg`=0). For 0x0A/0x0B the reg operand is the destination (`out_to_reg`=1). Even opcodes are 8-bit.
- R5: `out_size` is encoded 0=8, 1=16, 2=32, 3=64 bits. Full-size opcodes default to 32 bits. A 0x66 prefix gives 16 bits, and REX bit 3 (W) gives 64 bits even when 0x66 is present.
- R6: `out_imm` holds the immediate extended to the operand size, with every bit above that size cleared. A 4-byte immediate at 64-bit size is sign-extended. The 0x83 byte is sign-extended to the operand size. All other immediates are zero-extended.
- R7: A REX byte (0x40–0x4F) counts only as the last prefix before the opcode. Its bit 2 becomes bit 3 of `out_reg_idx`, and its bit 0 becomes bit 3 of `out_rm_idx`. A REX followed by another prefix is discarded.
- R8: ModRM mod=3 is a register r/m: `out_rm_idx` holds it and `out_dst_mem`=0. When mod≠3, `out_rm_idx`=0. mod=1 adds 1 displacement byte and mod=2 adds 4. mod=0 with rm=5 adds 4. rm=4 with mod≠3 adds a SIB byte, and that SIB byte with base bits [2:0]=5 under mod=0 adds 4.
- R9: A LOCK prefix (0xF0) sets `out_ud_fault` when the destination is a register, including every 0x0A/0x0B and accumulator form. It leaves the flag clear when the destination is memory.
- R10: `out_len` equals the number of bytes accepted for the instruction: prefixes, opcode, ModRM, SIB, displacement and immediate.
- R11: A byte in opcode position outside {0x08–0x0D, 0x80, 0x81, 0x83} that is not a prefix emits a record with `out_unsupported`=1, `out_len` set and all other fields 0. The next byte starts a new instruction.
- R12: Cycles with `in_valid` low are ignored, whatever `in_byte` carries.
- R13: `out_valid` is high for exactly one cycle, the cycle after the final byte of an instruction is accepted, and never while an instruction is still incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_byte` holds a stream byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decoded record present |
| out_size | output | 2 | Operand size code (0=8, 1=16, 2=32, 3=64) |
| out_to_reg | output | 1 | Destination is the ModRM reg operand |
| out_dst_mem | output | 1 | Destination is a memory operand |
| out_reg_idx | output | 4 | Reg operand index including REX extension |
| out_rm_idx | output | 4 | Register r/m index when mod=3, else 0 |
| out_imm | output | 64 | Extended immediate |
| out_len | output | LEN_W | Instruction length in bytes |
| out_ud_fault | output | 1 | LOCK used with a register destination |
| out_unsupported | output | 1 | Byte sequence is not an OR instruction |

## Verification
The assertions assume that no instruction runs longer than the length counter can hold (15 bytes with the default width). The stimulus keeps every instruction at 13 bytes or fewer, with at most two prefixes. The sweep covers every OR opcode under eight prefix arrangements and eight ModRM shapes, using two immediate patterns that differ in their sign bits. Stalled feeding and unsupported sequences are mixed in, so the one-cycle record pulse and the return to the prefix state are exercised between instructions.

// File: rtl/or_dec_pkg.sv
package or_dec_pkg;

   localparam int IMM_W = 64;

   typedef enum logic [1:0] {
      SZ8  = 2'd0,
      SZ16 = 2'd1,
      SZ32 = 2'd2,
      SZ64 = 2'd3
   } opsz_e;

   typedef enum logic [2:0] {
      ST_PFX   = 3'd0,
      ST_MODRM = 3'd1,
      ST_SIB   = 3'd2,
      ST_DISP  = 3'd3,
      ST_IMM   = 3'd4
   } dstate_e;

   typedef enum logic [2:0] {
      OC_NONE     = 3'd0,
      OC_ACC      = 3'd1,
      OC_GRP      = 3'd2,
      OC_RM_DEST  = 3'd3,
      OC_REG_DEST = 3'd4
   } opcls_e;

   typedef enum logic [1:0] {
      IK_NONE  = 2'd0,
      IK_BYTE  = 2'd1,
      IK_FULL  = 2'd2,
      IK_SBYTE = 2'd3
   } immk_e;

   typedef struct packed {
      logic   known;
      opcls_e cls;
      logic   wide;
      immk_e  immk;
   } opinfo_t;

endpackage

// File: rtl/or_dec_opclass.sv
module or_dec_opclass
   import or_dec_pkg::*;
(
   input  logic [7:0] op_byte,
   output opinfo_t    info
);

   always_comb begin
      info = '{known: 1'b0, cls: OC_NONE, wide: 1'b0, immk: IK_NONE};
      unique case (op_byte)
         8'h08: info = '{known: 1'b1, cls: OC_RM_DEST,  wide: 1'b0, immk: IK_NONE};
         8'h09: info = '{known: 1'b1, cls: OC_RM_DEST,  wide: 1'b1, immk: IK_NONE};
         8'h0A: info = '{known: 1'b1, cls: OC_REG_DEST, wide: 1'b0, immk: IK_NONE};
         8'h0B: info = '{known: 1'b1, cls: OC_REG_DEST, wide: 1'b1, immk: IK_NONE};
         8'h0C: info = '{known: 1'b1, cls: OC_ACC,      wide: 1'b0, immk: IK_BYTE};
         8'h0D: info = '{known: 1'b1, cls: OC_ACC,      wide: 1'b1, immk: IK_FULL};
         8'h80: info = '{known: 1'b1, cls: OC_GRP,      wide: 1'b0, immk: IK_BYTE};
         8'h81: info = '{known: 1'b1, cls: OC_GRP,      wide: 1'b1, immk: IK_FULL};
         8'h83: info = '{known: 1'b1, cls: OC_GRP,      wide: 1'b1, immk: IK_SBYTE};
         default: ;
      endcase
   end

endmodule

// File: rtl/or_dec_addr_len.sv
module or_dec_addr_len (
   input  logic [7:0] modrm_byte,
   input  logic [7:0] sib_byte,
   input  logic [1:0] held_mod,
   output logic       need_sib,
   output logic [2:0] disp_n,
   output logic [2:0] sib_disp_n
);

   logic [1:0] mod_f;
   logic [2:0] rm_f;

   assign mod_f = modrm_byte[7:6];
   assign rm_f  = modrm_byte[2:0];

   assign need_sib = (mod_f != 2'b11) && (rm_f == 3'd4);

   always_comb begin
      unique case (mod_f)
         2'b01:   disp_n = 3'd1;
         2'b10:   disp_n = 3'd4;
         2'b00:   disp_n = (rm_f == 3'd5) ? 3'd4 : 3'd0;
         default: disp_n = 3'd0;
      endcase
   end

   // base field 5 without a mod displacement means a 32-bit displacement
   assign sib_disp_n = ((held_mod == 2'b00) && (sib_byte[2:0] == 3'd5)) ? 3'd4 : 3'd0;

endmodule

// File: rtl/or_dec_imm_ext.sv
module or_dec_imm_ext
   import or_dec_pkg::*;
(
   input  logic [31:0]      raw,
   input  immk_e            kind,
   input  opsz_e            sz,
   output logic [IMM_W-1:0] ext,
   output logic [2:0]       n_bytes
);

   logic [IMM_W-1:0] widened;
   logic [IMM_W-1:0] size_mask;

   always_comb begin
      unique case (kind)
         IK_BYTE:  n_bytes = 3'd1;
         IK_SBYTE: n_bytes = 3'd1;
         IK_FULL:  n_bytes = (sz == SZ16) ? 3'd2 : 3'd4;
         default:  n_bytes = 3'd0;
      endcase
   end

   always_comb begin
      unique case (kind)
         IK_BYTE:  widened = {{(IMM_W-8){1'b0}}, raw[7:0]};
         IK_SBYTE: widened = {{(IMM_W-8){raw[7]}}, raw[7:0]};
         IK_FULL:  widened = {{(IMM_W-32){raw[31]}}, raw};
         default:  widened = '0;
      endcase
   end

   always_comb begin
      unique case (sz)
         SZ8:     size_mask = {{(IMM_W-8){1'b0}},  {8{1'b1}}};
         SZ16:    size_mask = {{(IMM_W-16){1'b0}}, {16{1'b1}}};
         SZ32:    size_mask = {{(IMM_W-32){1'b0}}, {32{1'b1}}};
         default: size_mask = {IMM_W{1'b1}};
      endcase
   end

   assign ext = widened & size_mask;

endmodule

// File: rtl/or_insn_decoder.sv
module or_insn_decoder
   import or_dec_pkg::*;
#(
   parameter int LEN_W   = 4,
   parameter int USE_REX = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             out_valid,
   output logic [1:0]       out_size,
   output logic             out_to_reg,
   output logic             out_dst_mem,
   output logic [3:0]       out_reg_idx,
   output logic [3:0]       out_rm_idx,
   output logic [63:0]      out_imm,
   output logic [LEN_W-1:0] out_len,
   output logic             out_ud_fault,
   output logic             out_unsupported
);

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   generate
      if (LEN_W < 4) begin : g_len_chk
         $error("or_insn_decoder: LEN_W must be at least 4");
      end
      if (IMM_W != 64) begin : g_imm_chk
         $error("or_insn_decoder: immediate width must be 64");
      end
   endgenerate

   // ---------------- state ----------------
   dstate_e          st_q, st_d;
   logic [LEN_W-1:0] len_q, len_d;
   logic             osz16_q, osz16_d;
   logic             lock_q, lock_d;
   logic             rex_vld_q, rex_vld_d;
   logic [2:0]       rex_q, rex_d;      // {W, R, B}
   opcls_e           cls_q, cls_d;
   immk_e            immk_q, immk_d;
   opsz_e            sz_q, sz_d;
   logic             rexr_q, rexr_d;
   logic             rexb_q, rexb_d;
   logic [7:0]       modrm_q, modrm_d;
   logic [2:0]       disp_q, disp_d;
   logic [2:0]       imm_q, imm_d;
   logic [1:0]       idx_q, idx_d;
   logic [31:0]      raw_q, raw_d;

   // ---------------- byte classification ----------------
   logic is_rex;
   generate
      if (USE_REX != 0) begin : g_rex
         assign is_rex = (in_byte[7:4] == 4'h4);
      end else begin : g_norex
         assign is_rex = 1'b0;
      end
   endgenerate

   opinfo_t op_info;
   or_dec_opclass u_cls (
      .op_byte (in_byte),
      .info    (op_info)
   );

   opsz_e op_sz;
   always_comb begin
      if (!op_info.wide)                op_sz = SZ8;
      else if (rex_vld_q && rex_q[2])   op_sz = SZ64;
      else if (osz16_q)                 op_sz = SZ16;
      else                              op_sz = SZ32;
   end

   logic       need_sib;
   logic [2:0] disp_n;
   logic [2:0] sib_disp_n;
   or_dec_addr_len u_addr (
      .modrm_byte (in_byte),
      .sib_byte   (in_byte),
      .held_mod   (modrm_q[7:6]),
      .need_sib   (need_sib),
      .disp_n     (disp_n),
      .sib_disp_n (sib_disp_n)
   );

   logic [31:0] raw_now;
   assign raw_now = raw_q | ({24'd0, in_byte} << {idx_q, 3'b000});

   immk_e      kind_sel;
   opsz_e      sz_sel;
   logic [63:0] imm_ext;
   logic [2:0]  imm_n;
   assign kind_sel = (st_q == ST_PFX) ? op_info.immk : immk_q;
   assign sz_sel   = (st_q == ST_PFX) ? op_sz : sz_q;

   or_dec_imm_ext u_imm (
      .raw     (raw_now),
      .kind    (kind_sel),
      .sz      (sz_sel),
      .ext     (imm_ext),
      .n_bytes (imm_n)
   );

   // ---------------- record fields ----------------
   logic [7:0] modrm_eff;
   logic       f_reg_mod;
   logic       f_dst_mem;
   logic       f_to_reg;
   logic [3:0] f_reg_idx;
   logic [3:0] f_rm_idx;
   logic       f_ud;

   assign modrm_eff = (st_q == ST_MODRM) ? in_byte : modrm_q;
   assign f_reg_mod = (modrm_eff[7:6] == 2'b11);
   assign f_dst_mem = ((cls_q == OC_RM_DEST) || (cls_q == OC_GRP)) && !f_reg_mod;
   assign f_to_reg  = (cls_q == OC_REG_DEST);
   assign f_reg_idx = (cls_q == OC_ACC) ? 4'd0 : {rexr_q, modrm_eff[5:3]};
   assign f_rm_idx  = ((cls_q != OC_ACC) && f_reg_mod) ? {rexb_q, modrm_eff[2:0]} : 4'd0;
   assign f_ud      = lock_q && !f_dst_mem;

   // ---------------- next state ----------------
   logic emit;
   logic emit_unsup;

   always_comb begin
      st_d      = st_q;
      len_d     = len_q;
      osz16_d   = osz16_q;
      lock_d    = lock_q;
      rex_vld_d = rex_vld_q;
      rex_d     = rex_q;
      cls_d     = cls_q;
      immk_d    = immk_q;
      sz_d      = sz_q;
      rexr_d    = rexr_q;
      rexb_d    = rexb_q;
      modrm_d   = modrm_q;
      disp_d    = disp_q;
      imm_d     = imm_q;
      idx_d     = idx_q;
      raw_d     = raw_q;
      emit      = 1'b0;
      emit_unsup = 1'b0;

      if (in_valid) begin
         len_d = len_q + LEN_ONE;
         unique case (st_q)
            ST_PFX: begin
               if (in_byte == 8'h66) begin
                  osz16_d   = 1'b1;
                  rex_vld_d = 1'b0;
               end else if (in_byte == 8'hF0) begin
                  lock_d    = 1'b1;
                  rex_vld_d = 1'b0;
               end else if (is_rex) begin
                  rex_d     = {in_byte[3], in_byte[2], in_byte[0]};
                  rex_vld_d = 1'b1;
               end else if (!op_info.known) begin
                  emit       = 1'b1;
                  emit_unsup = 1'b1;
               end else begin
                  cls_d  = op_info.cls;
                  immk_d = op_info.immk;
                  sz_d   = op_sz;
                  rexr_d = rex_vld_q && rex_q[1];
                  rexb_d = rex_vld_q && rex_q[0];
                  imm_d  = imm_n;
                  idx_d  = 2'd0;
                  raw_d  = 32'd0;
                  disp_d = 3'd0;
                  st_d   = (op_info.cls == OC_ACC) ? ST_IMM : ST_MODRM;
               end
            end
            ST_MODRM: begin
               modrm_d = in_byte;
               if ((cls_q == OC_GRP) && (in_byte[5:3] != 3'd1)) begin
                  emit       = 1'b1;
                  emit_unsup = 1'b1;
               end else begin
                  disp_d = disp_n;
                  if (need_sib)           st_d = ST_SIB;
                  else if (disp_n != 3'd0) st_d = ST_DISP;
                  else if (imm_q != 3'd0)  st_d = ST_IMM;
                  else                     emit = 1'b1;
               end
            end
            ST_SIB: begin
               disp_d = disp_q + sib_disp_n;
               if ((disp_q + sib_disp_n) != 3'd0) st_d = ST_DISP;
               else if (imm_q != 3'd0)             st_d = ST_IMM;
               else                                emit = 1'b1;
            end
            ST_DISP: begin
               disp_d = disp_q - 3'd1;
               if (disp_q == 3'd1) begin
                  if (imm_q != 3'd0) st_d = ST_IMM;
                  else               emit = 1'b1;
               end
            end
            ST_IMM: begin
               raw_d = raw_now;
               idx_d = idx_q + 2'd1;
               imm_d = imm_q - 3'd1;
               if (imm_q == 3'd1) emit = 1'b1;
            end
            default: st_d = ST_PFX;
         endcase

         if (emit) begin
            st_d      = ST_PFX;
            len_d     = '0;
            osz16_d   = 1'b0;
            lock_d    = 1'b0;
            rex_vld_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_PFX;
         len_q     <= '0;
         osz16_q   <= 1'b0;
         lock_q    <= 1'b0;
         rex_vld_q <= 1'b0;
         rex_q     <= '0;
         cls_q     <= OC_NONE;
         immk_q    <= IK_NONE;
         sz_q      <= SZ8;
         rexr_q    <= 1'b0;
         rexb_q    <= 1'b0;
         modrm_q   <= '0;
         disp_q    <= '0;
         imm_q     <= '0;
         idx_q     <= '0;
         raw_q     <= '0;
      end else begin
         st_q      <= st_d;
         len_q     <= len_d;
         osz16_q   <= osz16_d;
         lock_q    <= lock_d;
         rex_vld_q <= rex_vld_d;
         rex_q     <= rex_d;
         cls_q     <= cls_d;
         immk_q    <= immk_d;
         sz_q      <= sz_d;
         rexr_q    <= rexr_d;
         rexb_q    <= rexb_d;
         modrm_q   <= modrm_d;
         disp_q    <= disp_d;
         imm_q     <= imm_d;
         idx_q     <= idx_d;
         raw_q     <= raw_d;
      end
   end

   // ---------------- registered record ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_size        <= '0;
         out_to_reg      <= 1'b0;
         out_dst_mem     <= 1'b0;
         out_reg_idx     <= '0;
         out_rm_idx      <= '0;
         out_imm         <= '0;
         out_len         <= '0;
         out_ud_fault    <= 1'b0;
         out_unsupported <= 1'b0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_len         <= len_q + LEN_ONE;
            out_unsupported <= emit_unsup;
            if (emit_unsup) begin
               out_size     <= '0;
               out_to_reg   <= 1'b0;
               out_dst_mem  <= 1'b0;
               out_reg_idx  <= '0;
               out_rm_idx   <= '0;
               out_imm      <= '0;
               out_ud_fault <= 1'b0;
            end else begin
               out_size     <= sz_q;
               out_to_reg   <= f_to_reg;
               out_dst_mem  <= f_dst_mem;
               out_reg_idx  <= f_reg_idx;
               out_rm_idx   <= f_rm_idx;
               out_imm      <= (st_q == ST_IMM) ? imm_ext : 64'd0;
               out_ud_fault <= f_ud;
            end
         end
      end
   end

endmodule

// File: rtl/or_dec_checker.sv
module or_dec_checker #(
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [1:0]       out_size,
   input logic             out_to_reg,
   input logic             out_dst_mem,
   input logic [3:0]       out_rm_idx,
   input logic [63:0]      out_imm,
   input logic [LEN_W-1:0] out_len,
   input logic             out_ud_fault,
   input logic             out_unsupported
);

   // R13: a record only follows an accepted byte
   p_after_byte_r13: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R9: fault flag never accompanies a memory destination
   p_ud_regdst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ud_fault) |-> !out_dst_mem);

   // R11: unsupported records carry no decoded content
   p_unsup_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_unsupported) |-> (!out_ud_fault && !out_dst_mem && !out_to_reg && out_imm == 64'd0));

   // R6: only a 64-bit operand may have immediate bits above 31
   p_imm_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_size != 2'd3) |-> (out_imm[63:32] == 32'd0));

   // R6: 8-bit operand keeps the immediate within a byte
   p_imm_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_size == 2'd0) |-> (out_imm[31:8] == 24'd0));

   // R10: any decoded OR is at least two bytes long
   p_len_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_unsupported) |-> (out_len >= LEN_W'(2)));

   // R4: a reg destination is never memory
   p_dir_regdst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_to_reg) |-> !out_dst_mem);

   // R8: a nonzero r/m index implies a register r/m operand
   p_rm_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_rm_idx != 4'd0) |-> !out_dst_mem);

endmodule

bind or_insn_decoder or_dec_checker #(.LEN_W(LEN_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .out_valid       (out_valid),
   .out_size        (out_size),
   .out_to_reg      (out_to_reg),
   .out_dst_mem     (out_dst_mem),
   .out_rm_idx      (out_rm_idx),
   .out_imm         (out_imm),
   .out_len         (out_len),
   .out_ud_fault    (out_ud_fault),
   .out_unsupported (out_unsupported)
);

// File: tb/or_insn_decoder_tb_top.sv
`timescale 1ns/100ps
module or_insn_decoder_tb_top;

   localparam int LEN_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_byte = 8'h00;
   logic             out_valid;
   logic [1:0]       out_size;
   logic             out_to_reg;
   logic             out_dst_mem;
   logic [3:0]       out_reg_idx;
   logic [3:0]       out_rm_idx;
   logic [63:0]      out_imm;
   logic [LEN_W-1:0] out_len;
   logic             out_ud_fault;
   logic             out_unsupported;

   always #2.5 clk = ~clk;

   or_insn_decoder #(.LEN_W(LEN_W), .USE_REX(1)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .in_valid        (in_valid),
      .in_byte         (in_byte),
      .out_valid       (out_valid),
      .out_size        (out_size),
      .out_to_reg      (out_to_reg),
      .out_dst_mem     (out_dst_mem),
      .out_reg_idx     (out_reg_idx),
      .out_rm_idx      (out_rm_idx),
      .out_imm         (out_imm),
      .out_len         (out_len),
      .out_ud_fault    (out_ud_fault),
      .out_unsupported (out_unsupported)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [7:0] seq [0:15];
   int         seq_n;

   function automatic logic [82:0] pack_rec(input logic v, input logic [1:0] sz, input logic dir,
                                            input logic mem, input logic [3:0] ri, input logic [3:0] mi,
                                            input logic [63:0] imm, input logic [3:0] len,
                                            input logic ud, input logic un);
      return {v, sz, dir, mem, ri, mi, imm, len, ud, un};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [82:0] act, input logic [82:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // feed seq[0..seq_n-1]; returns whether out_valid rose too early
   task automatic feed(input bit stall, output bit early);
      early = 1'b0;
      for (int i = 0; i < seq_n; i++) begin
         @(negedge clk);
         if (i > 0 && out_valid) early = 1'b1;
         if (stall && i > 0) begin
            in_valid = 1'b0;
            in_byte  = 8'hFF;
            @(negedge clk);
            if (out_valid) early = 1'b1;
         end
         in_valid = 1'b1;
         in_byte  = seq[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h5A;
   endtask

   task automatic verify(input logic [82:0] exp, input string tag, input bit early);
      logic [82:0] act;
      act = pack_rec(out_valid, out_size, out_to_reg, out_dst_mem, out_reg_idx, out_rm_idx,
                     out_imm, out_len, out_ud_fault, out_unsupported);
      check(act == exp, tag, act, exp);
      check(!early, "R13 early pulse", {82'd0, early}, 83'd0);
      @(negedge clk);
      check(!out_valid, "R13 single pulse", {82'd0, out_valid}, 83'd0);
   endtask

   task automatic push(input logic [7:0] b);
      seq[seq_n] = b;
      seq_n++;
   endtask

   task automatic run_case(input int pk, input logic [7:0] op, input logic [7:0] mr_in,
                           input logic [7:0] sib, input logic [31:0] immv, input bit stall);
      bit has66, lock, rex_last, acc, grp, wide, regdst, rw, rr, rb, early;
      logic [3:0] rexv;
      logic [1:0] sz;
      logic [7:0] mr;
      logic [63:0] eimm, mask;
      int dn, ni;
      bit ex_mem;
      logic [3:0] ex_reg, ex_rm;
      string tag;
      seq_n = 0;
      has66 = 0; lock = 0; rex_last = 0; rexv = 4'h0;
      case (pk)
         1: begin push(8'h66); has66 = 1; end
         2: begin push(8'h4D); rexv = 4'hD; rex_last = 1; end
         3: begin push(8'h66); push(8'h4D); has66 = 1; rexv = 4'hD; rex_last = 1; end
         4: begin push(8'h4D); push(8'h66); has66 = 1; end
         5: begin push(8'hF0); lock = 1; end
         6: begin push(8'hF0); push(8'h45); lock = 1; rexv = 4'h5; rex_last = 1; end
         7: begin push(8'h45); rexv = 4'h5; rex_last = 1; end
         default: ;
      endcase
      acc    = (op == 8'h0C) || (op == 8'h0D);
      grp    = (op == 8'h80) || (op == 8'h81) || (op == 8'h83);
      regdst = (op == 8'h0A) || (op == 8'h0B);
      wide   = op[0];
      rw = rex_last & rexv[3];
      rr = rex_last & rexv[2];
      rb = rex_last & rexv[0];
      sz = !wide ? 2'd0 : rw ? 2'd3 : has66 ? 2'd1 : 2'd2;
      mr = grp ? ((mr_in & 8'hC7) | 8'h08) : mr_in;
      push(op);
      dn = 0;
      if (!acc) begin
         push(mr);
         if (mr[7:6] != 2'b11 && mr[2:0] == 3'd4) push(sib);
         if (mr[7:6] == 2'b01) dn = 1;
         else if (mr[7:6] == 2'b10) dn = 4;
         else if (mr[7:6] == 2'b00 && mr[2:0] == 3'd5) dn = 4;
         else if (mr[7:6] == 2'b00 && mr[2:0] == 3'd4 && sib[2:0] == 3'd5) dn = 4;
         for (int k = 0; k < dn; k++) push(8'hA0 + 8'(k));
      end
      if (op == 8'h0C || op == 8'h80 || op == 8'h83) ni = 1;
      else if (op == 8'h0D || op == 8'h81) ni = (sz == 2'd1) ? 2 : 4;
      else ni = 0;
      for (int k = 0; k < ni; k++) push(immv[8*k +: 8]);
      case (sz)
         2'd0: mask = 64'hFF;
         2'd1: mask = 64'hFFFF;
         2'd2: mask = 64'hFFFF_FFFF;
         default: mask = {64{1'b1}};
      endcase
      if (ni == 0)            eimm = 64'd0;
      else if (op == 8'h83)   eimm = {{56{immv[7]}}, immv[7:0]} & mask;
      else if (ni == 1)       eimm = {56'd0, immv[7:0]};
      else if (ni == 2)       eimm = {48'd0, immv[15:0]};
      else if (sz == 2'd3)    eimm = {{32{immv[31]}}, immv};
      else                    eimm = {32'd0, immv};
      ex_mem = !acc && (mr[7:6] != 2'b11) && !regdst;
      ex_reg = acc ? 4'd0 : {rr, mr[5:3]};
      ex_rm  = (!acc && mr[7:6] == 2'b11) ? {rb, mr[2:0]} : 4'd0;
      tag = acc ? "R2" : grp ? "R3" : "R4";
      tag = {tag, " R5 R6 R10"};
      if (pk >= 2 && pk != 5) tag = {tag, " R7"};
      if (!acc) tag = {tag, " R8"};
      if (lock) tag = {tag, " R9"};
      if (stall) tag = {tag, " R12"};
      feed(stall, early);
      verify(pack_rec(1'b1, sz, regdst, ex_mem, ex_reg, ex_rm, eimm, 4'(seq_n),
                      lock && !ex_mem, 1'b0), tag, early);
   endtask

   task automatic run_unsup(input string tag);
      bit early;
      int n;
      n = seq_n;
      feed(1'b0, early);
      verify(pack_rec(1'b1, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 64'd0, 4'(n), 1'b0, 1'b1), tag, early);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] ops [0:8];
      logic [7:0] mrs [0:7];
      ops = '{8'h0C, 8'h0D, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h80, 8'h81, 8'h83};
      mrs = '{8'hC3, 8'h05, 8'h04, 8'h46, 8'h84, 8'h0E, 8'hF9, 8'h3C};

      // R1: quiet during and after reset
      repeat (3) @(negedge clk);
      check(!out_valid, "R1 in reset", {82'd0, out_valid}, 83'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!out_valid, "R1 after reset", {82'd0, out_valid}, 83'd0);

      // R12: garbage bytes with in_valid low produce nothing
      in_byte = 8'h09;
      repeat (4) @(negedge clk);
      check(!out_valid, "R12 idle bytes", {82'd0, out_valid}, 83'd0);

      // R11: non-OR opcodes
      seq_n = 0; push(8'h01);
      run_unsup("R11 opcode 01");
      seq_n = 0; push(8'h66); push(8'h31);
      run_unsup("R11 prefixed 31 R10");
      run_case(0, 8'h09, 8'hC3, 8'h00, 32'h0, 1'b0);

      // R3: group with other reg fields
      seq_n = 0; push(8'h81); push(8'hD0);
      run_unsup("R3 reg2 group");
      seq_n = 0; push(8'hF0); push(8'h4D); push(8'h80); push(8'hF8);
      run_unsup("R3 reg7 group R11");
      run_case(5, 8'h83, 8'h0E, 8'h00, 32'h0000_00F0, 1'b0);

      // near-exhaustive sweep
      for (int pk = 0; pk < 8; pk++)
         for (int oi = 0; oi < 9; oi++)
            for (int mi = 0; mi < 8; mi++)
               for (int iv = 0; iv < 2; iv++)
                  run_case(pk, ops[oi], mrs[mi], (iv == 1) ? 8'h25 : 8'h11,
                           (iv == 1) ? 32'hF0E1_D2C3 : 32'h1234_5678,
                           (iv == 1) && (mi == 3));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule